// File: doc/BRIEF.md
# Four-Channel Stereo Sample Mixer

This block takes the instantaneous output levels of four audio voices and folds them into one stereo stream. Each voice supplies a signed 8-bit level and a pulse-width gate bit; a gated-off voice adds nothing. Voices 1 and 2 make up the left side and voices 0 and 3 the right side. Each side's two-term sum is scaled up by 128 to fill a signed 16-bit word. On every sample tick the pair is captured and sent out as two beats on a valid/ready stream, the left beat first and then the right beat.

The same block holds three control words that a host writes through a single write strobe with a register select: a DMA enable word, a modulation word and an interrupt request word. It presents the decoded per-voice bits as plain outputs. It also routes each voice's attach flags to the voice above it, so that each voice knows whether its period or volume is being driven by its lower neighbour.

Back-pressure rules: a beat stays on the stream, with unchanged data, for as long as ready is low. A tick is taken only when no pair is outstanding, or in the same cycle that the right beat is taken. A tick that arrives at any other time is dropped. Levels are sampled in the cycle of the tick that is taken.

Top module: `amix_stereo_mixer`

## Requirements
- R1: After reset the stream is idle (`m_valid_o` low), and every decoded control output and every routed target bit is 0.
- R2: An accepted tick makes the next cycle present a left beat (`m_right_o`=0) whose value is (g1·L1 + g2·L2)·128. Here Ln is voice n's signed level taken from `level_i[8n+7:8n]` and gn is `gate_i[n]`.
- R3: Once the left beat is taken, the following beat is the right beat (`m_right_o`=1), whose value is (g0·L0 + g3·L3)·128.
- R4: A voice whose gate bit is 0 adds nothing to its side, whatever its level.
- R5: The seven low bits of every beat are 0. Two voices both at -128 give exactly -32768, and two at +127 give 32512, with no wrap.
- R6: While `m_valid_o` is high and `m_ready_i` is low, the beat's data and side flag stay unchanged.
- R7: A tick is ignored while a pair is outstanding, except in the cycle in which the right beat is taken; such a tick loads a new pair whose left beat follows at once.
- R8: A write with select 0 loads `dma_en_o[n]` from data bit n, for n = 0..3.
- R9: A write with select 1 loads the attach-period flags `att_per_o[n]` from data bit 4+n, and the attach-volume flags `att_vol_o[n]` from data bit n.
- R10: `per_tgt_o[n]` equals `att_per_o[n-1]` and `vol_tgt_o[n]` equals `att_vol_o[n-1]` for n = 1..3. Both target bits of voice 0 are always 0, and the flags of voice 3 reach no target.
- R11: A write with select 2 loads `irq_pend_o[n]` from data bit 7+n. The other data bits are ignored.
- R12: A write changes only the register its select names. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 32 | Four signed 8-bit voice levels, voice n in bits 8n+7:8n |
| gate_i | input | 4 | Per-voice pulse-width gate, 1 lets the level through |
| tick_i | input | 1 | Sample tick, one cycle per output pair |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_sel_i | input | 2 | Register select: 0 DMA enables, 1 modulation, 2 interrupt request |
| ctl_data_i | input | 16 | Control write data |
| m_ready_i | input | 1 | Stream consumer ready |
| m_valid_o | output | 1 | Stream beat valid |
| m_data_o | output | 16 | Signed 16-bit sample |
| m_right_o | output | 1 | 0 for the left beat, 1 for the right beat |
| dma_en_o | output | 4 | Per-voice DMA enable |
| att_per_o | output | 4 | Per-voice attach-period flag |
| att_vol_o | output | 4 | Per-voice attach-volume flag |
| irq_pend_o | output | 4 | Per-voice interrupt pending |
| per_tgt_o | output | 4 | Voice's period is driven by its lower neighbour |
| vol_tgt_o | output | 4 | Voice's volume is driven by its lower neighbour |

## Verification
The hardest case to reach from the ports is a tick that lands in exactly the cycle in which the right beat is taken. It must load a new pair, while a tick one cycle earlier or during a stall must be lost. The stimulus holds ready high, raises the tick in the cycle the right beat is on the stream, and then checks for a fresh left beat made from the new levels. A separate stall test holds ready low across several cycles, changes the levels and pulses the tick in the middle. It then checks that the old pair drains unchanged and that the stream goes idle afterwards.

// File: rtl/amix_pkg.sv
package amix_pkg;
  localparam int NUM_CH   = 4;
  localparam int LEVEL_W  = 8;
  localparam int SHIFT    = 7;
  localparam int SUM_W    = LEVEL_W + 1;
  localparam int SAMPLE_W = SUM_W + SHIFT;
  localparam int CTL_W    = 16;
  localparam int IRQ_BASE = 7;

  // fixed stereo pairing: left = voices 1,2 ; right = voices 0,3
  localparam int LEFT_A  = 1;
  localparam int LEFT_B  = 2;
  localparam int RIGHT_A = 0;
  localparam int RIGHT_B = 3;

  typedef enum logic [1:0] {
    SEL_DMA = 2'd0,
    SEL_MOD = 2'd1,
    SEL_IRQ = 2'd2
  } ctl_sel_e;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_LEFT  = 2'd1,
    SER_RIGHT = 2'd2
  } ser_state_e;
endpackage

// File: rtl/amix_ctrl_decode.sv
module amix_ctrl_decode
  import amix_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int DATA_W = CTL_W,
  parameter int IRQ_LO = IRQ_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [N_CH-1:0]   dma_en_o,
  output logic [N_CH-1:0]   att_per_o,
  output logic [N_CH-1:0]   att_vol_o,
  output logic [N_CH-1:0]   irq_pend_o,
  output logic [N_CH-1:0]   per_tgt_o,
  output logic [N_CH-1:0]   vol_tgt_o
);
  logic unused_ctl;
  assign unused_ctl = ^data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en_o   <= '0;
      att_per_o  <= '0;
      att_vol_o  <= '0;
      irq_pend_o <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_DMA: dma_en_o <= data_i[N_CH-1:0];
        SEL_MOD: begin
          att_vol_o <= data_i[N_CH-1:0];
          att_per_o <= data_i[N_CH +: N_CH];
        end
        SEL_IRQ: irq_pend_o <= data_i[IRQ_LO +: N_CH];
        default: ;
      endcase
    end
  end

  // each voice is modulated by the voice just below it
  for (genvar n = 0; n < N_CH; n++) begin : g_route
    if (n == 0) begin : g_base
      assign per_tgt_o[n] = 1'b0;
      assign vol_tgt_o[n] = 1'b0;
    end else begin : g_chain
      assign per_tgt_o[n] = att_per_o[n-1];
      assign vol_tgt_o[n] = att_vol_o[n-1];
    end
  end
endmodule

// File: rtl/amix_pair_sum.sv
module amix_pair_sum
  import amix_pkg::*;
#(
  parameter int N_CH  = NUM_CH,
  parameter int LVL_W = LEVEL_W,
  parameter int SH    = SHIFT,
  parameter int CH_A  = 0,
  parameter int CH_B  = 1
) (
  input  logic [N_CH*LVL_W-1:0]  level_i,
  input  logic [N_CH-1:0]        gate_i,
  output logic [LVL_W+SH:0]      sample_o
);
  localparam int SW = LVL_W + 1;

  logic [1:0][SW-1:0] term;
  logic signed [SW-1:0] sum;

  for (genvar k = 0; k < 2; k++) begin : g_term
    localparam int CH = (k == 0) ? CH_A : CH_B;
    logic [LVL_W-1:0] lv;
    assign lv      = level_i[CH*LVL_W +: LVL_W];
    assign term[k] = gate_i[CH] ? {lv[LVL_W-1], lv} : '0;
  end

  assign sum      = $signed(term[0]) + $signed(term[1]);
  assign sample_o = {sum, {SH{1'b0}}};
endmodule

// File: rtl/amix_pair_serializer.sv
module amix_pair_serializer
  import amix_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic         m_ready_i,
  output logic         m_valid_o,
  output logic [W-1:0] m_data_o,
  output logic         m_right_o
);
  ser_state_e   state;
  logic [W-1:0] left_q, right_q;
  logic         take;

  assign take = (state == SER_IDLE) || (state == SER_RIGHT && m_ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SER_IDLE;
      left_q  <= '0;
      right_q <= '0;
    end else if (tick_i && take) begin
      left_q  <= left_i;
      right_q <= right_i;
      state   <= SER_LEFT;
    end else begin
      case (state)
        SER_LEFT:  if (m_ready_i) state <= SER_RIGHT;
        SER_RIGHT: if (m_ready_i) state <= SER_IDLE;
        default:   state <= SER_IDLE;
      endcase
    end
  end

  assign m_valid_o = (state != SER_IDLE);
  assign m_right_o = (state == SER_RIGHT);
  assign m_data_o  = (state == SER_RIGHT) ? right_q : left_q;
endmodule

// File: rtl/amix_stereo_mixer.sv
module amix_stereo_mixer
  import amix_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int LVL_W  = LEVEL_W,
  parameter int SH     = SHIFT,
  parameter int DATA_W = CTL_W,
  parameter int IRQ_LO = IRQ_BASE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH*LVL_W-1:0]   level_i,
  input  logic [N_CH-1:0]         gate_i,
  input  logic                    tick_i,
  input  logic                    ctl_wr_i,
  input  logic [1:0]              ctl_sel_i,
  input  logic [DATA_W-1:0]       ctl_data_i,
  input  logic                    m_ready_i,
  output logic                    m_valid_o,
  output logic [LVL_W+SH:0]       m_data_o,
  output logic                    m_right_o,
  output logic [N_CH-1:0]         dma_en_o,
  output logic [N_CH-1:0]         att_per_o,
  output logic [N_CH-1:0]         att_vol_o,
  output logic [N_CH-1:0]         irq_pend_o,
  output logic [N_CH-1:0]         per_tgt_o,
  output logic [N_CH-1:0]         vol_tgt_o
);
  localparam int OW = LVL_W + SH + 1;

  logic [OW-1:0] left_mix, right_mix;

  amix_ctrl_decode #(.N_CH(N_CH), .DATA_W(DATA_W), .IRQ_LO(IRQ_LO)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (ctl_wr_i),
    .sel_i      (ctl_sel_i),
    .data_i     (ctl_data_i),
    .dma_en_o   (dma_en_o),
    .att_per_o  (att_per_o),
    .att_vol_o  (att_vol_o),
    .irq_pend_o (irq_pend_o),
    .per_tgt_o  (per_tgt_o),
    .vol_tgt_o  (vol_tgt_o)
  );

  amix_pair_sum #(.N_CH(N_CH), .LVL_W(LVL_W), .SH(SH),
                  .CH_A(LEFT_A), .CH_B(LEFT_B)) u_left (
    .level_i  (level_i),
    .gate_i   (gate_i),
    .sample_o (left_mix)
  );

  amix_pair_sum #(.N_CH(N_CH), .LVL_W(LVL_W), .SH(SH),
                  .CH_A(RIGHT_A), .CH_B(RIGHT_B)) u_right (
    .level_i  (level_i),
    .gate_i   (gate_i),
    .sample_o (right_mix)
  );

  amix_pair_serializer #(.W(OW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .left_i    (left_mix),
    .right_i   (right_mix),
    .m_ready_i (m_ready_i),
    .m_valid_o (m_valid_o),
    .m_data_o  (m_data_o),
    .m_right_o (m_right_o)
  );
endmodule

// File: rtl/amix_checker.sv
module amix_checker #(
  parameter int N_CH = 4,
  parameter int SH   = 7,
  parameter int OW   = 16,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            ctl_wr_i,
  input logic [1:0]      ctl_sel_i,
  input logic [DW-1:0]   ctl_data_i,
  input logic            m_ready_i,
  input logic            m_valid_o,
  input logic [OW-1:0]   m_data_o,
  input logic            m_right_o,
  input logic [N_CH-1:0] dma_en_o,
  input logic [N_CH-1:0] per_tgt_o
);
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid_o && tick_i) |=> (m_valid_o && !m_right_o)); // R2

  AST_LEFT_THEN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_ready_i && !m_right_o) |=> (m_valid_o && m_right_o)); // R3

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> (m_data_o[SH-1:0] == '0)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_right_o))); // R6

  AST_PAIR_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_ready_i && m_right_o && !tick_i) |=> !m_valid_o); // R7

  AST_DMA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_sel_i == 2'd0) |=> (dma_en_o == $past(ctl_data_i[N_CH-1:0]))); // R8

  AST_PERIOD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_sel_i == 2'd1) |=>
      (per_tgt_o[N_CH-1:1] == $past(ctl_data_i[N_CH +: N_CH-1]))); // R10
endmodule

bind amix_stereo_mixer amix_checker #(.N_CH(N_CH), .SH(SH), .OW(LVL_W+SH+1), .DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .ctl_wr_i   (ctl_wr_i),
  .ctl_sel_i  (ctl_sel_i),
  .ctl_data_i (ctl_data_i),
  .m_ready_i  (m_ready_i),
  .m_valid_o  (m_valid_o),
  .m_data_o   (m_data_o),
  .m_right_o  (m_right_o),
  .dma_en_o   (dma_en_o),
  .per_tgt_o  (per_tgt_o)
);

// File: tb/tb_amix_stereo_mixer.sv
module tb_amix_stereo_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] level_i = '0;
  logic [3:0]  gate_i = '0;
  logic        tick_i = 1'b0;
  logic        ctl_wr_i = 1'b0;
  logic [1:0]  ctl_sel_i = '0;
  logic [15:0] ctl_data_i = '0;
  logic        m_ready_i = 1'b1;
  logic        m_valid_o;
  logic [15:0] m_data_o;
  logic        m_right_o;
  logic [3:0]  dma_en_o, att_per_o, att_vol_o, irq_pend_o, per_tgt_o, vol_tgt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  amix_stereo_mixer dut (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .gate_i(gate_i), .tick_i(tick_i),
    .ctl_wr_i(ctl_wr_i), .ctl_sel_i(ctl_sel_i), .ctl_data_i(ctl_data_i),
    .m_ready_i(m_ready_i), .m_valid_o(m_valid_o), .m_data_o(m_data_o),
    .m_right_o(m_right_o), .dma_en_o(dma_en_o), .att_per_o(att_per_o),
    .att_vol_o(att_vol_o), .irq_pend_o(irq_pend_o), .per_tgt_o(per_tgt_o),
    .vol_tgt_o(vol_tgt_o)
  );

  // stimulus: {level3, level2, level1, level0, gates}
  localparam logic [35:0] VEC [8] = '{
    {32'h01_02_03_04, 4'hF},
    {32'h7F_7F_7F_7F, 4'hF},
    {32'h80_7F_01_FF, 4'hF},
    {32'h10_20_30_40, 4'h5},
    {32'h10_20_30_40, 4'hA},
    {32'hF0_E0_D0_C0, 4'h0},
    {32'hFF_FF_FF_FF, 4'h9},
    {32'h55_AA_33_CC, 4'h6}
  };

  function automatic int voice(input logic [31:0] lv, input logic [3:0] g, input int ch);
    return g[ch] ? int'($signed(lv[ch*8 +: 8])) : 0;
  endfunction

  function automatic int exp_left(input logic [31:0] lv, input logic [3:0] g);
    return (voice(lv, g, 1) + voice(lv, g, 2)) * 128;
  endfunction

  function automatic int exp_right(input logic [31:0] lv, input logic [3:0] g);
    return (voice(lv, g, 0) + voice(lv, g, 3)) * 128;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sdata();
    return int'($signed(m_data_o));
  endfunction

  task automatic ctl_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    ctl_wr_i = 1'b1; ctl_sel_i = sel; ctl_data_i = d;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  // tick with ready high, check left, right, idle
  task automatic play_pair(input string req, input logic [31:0] lv, input logic [3:0] g);
    @(negedge clk);
    level_i = lv; gate_i = g; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check({req, " left valid"}, int'(m_valid_o), 1);
    check({req, " left side"}, int'(m_right_o), 0);
    check({req, " left value"}, sdata(), exp_left(lv, g));
    @(negedge clk);
    check({req, " right side"}, int'(m_right_o), 1);
    check({req, " right value"}, sdata(), exp_right(lv, g));
    @(negedge clk);
    check({req, " idle after pair"}, int'(m_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old_lv;
    logic [3:0]  old_g;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", int'(m_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(m_valid_o), 0);
    check("R1 dma", int'(dma_en_o), 0);
    check("R1 attach", int'({att_per_o, att_vol_o}), 0);
    check("R1 irq", int'(irq_pend_o), 0);
    check("R1 targets", int'({per_tgt_o, vol_tgt_o}), 0);

    // R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      play_pair($sformatf("R2/R3/R4 vec%0d", i), VEC[i][35:4], VEC[i][3:0]);
    end

    // R5 extremes
    play_pair("R5 full negative", 32'h80808080, 4'hF);
    check("R5 min is -32768", exp_left(32'h80808080, 4'hF), -32768);
    play_pair("R5 full positive", 32'h7F7F7F7F, 4'hF);

    // R4 gate off with large levels on right only
    play_pair("R4 gated right", 32'h80_00_00_80, 4'h6);

    // R6 stall, R7 tick during stall ignored
    old_lv = 32'h11_22_33_44; old_g = 4'hF;
    @(negedge clk);
    m_ready_i = 1'b0; level_i = old_lv; gate_i = old_g; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R6 held valid", int'(m_valid_o), 1);
      check("R6 held side", int'(m_right_o), 0);
      check("R6 held value", sdata(), exp_left(old_lv, old_g));
      level_i = 32'h7F7F7F7F; tick_i = (k == 1);
      @(negedge clk);
      tick_i = 1'b0;
    end
    check("R7 still old left", sdata(), exp_left(old_lv, old_g));
    m_ready_i = 1'b1;
    @(negedge clk);
    check("R7 old right", sdata(), exp_right(old_lv, old_g));
    @(negedge clk);
    check("R7 tick during stall dropped", int'(m_valid_o), 0);

    // R7 tick in the cycle the right beat is taken
    @(negedge clk);
    level_i = old_lv; gate_i = old_g; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R7 first left", sdata(), exp_left(old_lv, old_g));
    @(negedge clk);
    check("R7 first right", sdata(), exp_right(old_lv, old_g));
    level_i = 32'hC0_10_F0_20; gate_i = 4'hF; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R7 back-to-back valid", int'(m_valid_o), 1);
    check("R7 back-to-back side", int'(m_right_o), 0);
    check("R7 back-to-back left", sdata(), exp_left(32'hC0_10_F0_20, 4'hF));
    @(negedge clk);
    check("R7 back-to-back right", sdata(), exp_right(32'hC0_10_F0_20, 4'hF));
    @(negedge clk);
    check("R7 idle", int'(m_valid_o), 0);

    // R8 DMA enable word
    ctl_write(2'd0, 16'hFFF5);
    check("R8 dma", int'(dma_en_o), 5);
    check("R12 dma write leaves attach", int'({att_per_o, att_vol_o}), 0);
    check("R12 dma write leaves irq", int'(irq_pend_o), 0);

    // R9 R10 modulation word
    ctl_write(2'd1, 16'hFFA6);
    check("R9 attach period", int'(att_per_o), 4'hA);
    check("R9 attach volume", int'(att_vol_o), 4'h6);
    check("R10 period targets", int'(per_tgt_o), int'({3'b010, 1'b0}));
    check("R10 volume targets", int'(vol_tgt_o), int'({3'b110, 1'b0}));
    check("R12 mod write leaves dma", int'(dma_en_o), 5);

    ctl_write(2'd1, 16'h0088);
    check("R10 voice3 flags set", int'({att_per_o[3], att_vol_o[3]}), 3);
    check("R10 voice3 reaches nothing", int'({per_tgt_o, vol_tgt_o}), 0);

    // R11 interrupt word
    ctl_write(2'd2, 16'h0280);
    check("R11 irq bits 7..10", int'(irq_pend_o), 5);
    ctl_write(2'd2, 16'hF87F);
    check("R11 other bits ignored", int'(irq_pend_o), 0);

    // R12 select 3 changes nothing
    ctl_write(2'd3, 16'hFFFF);
    check("R12 sel3 dma", int'(dma_en_o), 5);
    check("R12 sel3 attach", int'({att_per_o, att_vol_o}), 8'h88);
    check("R12 sel3 irq", int'(irq_pend_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule